// File: doc/BRIEF.md
# Bus-Watch Debug Trigger Controller

This block watches the bus cycles of a small 8-bit processor and decides when to capture them and when to stop the processor. Two address comparators look at every valid bus cycle. Each comparator can optionally be limited to read cycles only or to write cycles only. When a capture run is armed, each comparator hit pushes the matching address into an eight-entry trace FIFO. A debugger reads the FIFO back through a dedicated pop port.

Software sets the block up through a small byte-wide register port. The control byte enables the block, arms a run, selects the break type, enables breaks and holds the read/write qualifiers. A mode register selects the trace style. In end trace, the first hit finishes the run. In begin trace, hits are collected until the FIFO fills. When a run finishes, the arm bit drops and a one-cycle completion pulse is produced. If breaks are enabled, a break request of tag or force type is issued in the same cycle as that pulse. While the secure input is high, the block cannot be enabled.

Top module: `bus_watch_trig`

## Requirements
- R1: After reset, the control byte (offset 0) reads 0x00, the FIFO level is 0, and brkReq, brkTag and runDone are low.
- R2: The control byte is readable and writable at any time. Its bit layout is: bit7 enable, bit6 arm, bit5 tag, bit4 break-enable, bit3 rw-value A, bit2 rw-enable A, bit1 rw-value B, bit0 rw-enable B. A write without the arm bit reads back unchanged.
- R3: While secure is high, the enable and arm bits are forced to 0, and a write that tries to set enable leaves it 0.
- R4: A control write with both enable and arm set arms a run and empties the FIFO. A write with arm set but enable clear leaves arm at 0.
- R5: A comparator hits on a valid cycle whose address equals its match register. If its rw-enable bit is set, the cycle must also be a read (busRw=1) when its rw-value bit is 1, or a write (busRw=0) when that bit is 0. If rw-enable is clear, busRw is ignored.
- R6: In end trace (mode bit0 = 0), the first armed hit stores its address and completes the run. In the next cycle, runDone is high for exactly one cycle and the arm bit reads 0.
- R7: In begin trace (mode bit0 = 1), every armed hit is stored. The run completes on the hit that brings the FIFO to 8 entries, at which point fifoFull is high. Later hits are not stored.
- R8: When break-enable is 1, brkReq pulses together with runDone, and brkTag equals the tag bit (1 = tag type, 0 = force type). When break-enable is 0, no request is made, but data is still stored and the run still completes.
- R9: Writing 0 to enable or to arm stops a run at once. Any hit that occurs in the same cycle as a control-byte write is ignored.
- R10: A pulse on fifoRd removes the oldest entry, and fifoDout always shows the oldest entry. A pop while the FIFO is empty has no effect.
- R11: The match registers are written and read byte-wise: offset 1 is the mode register, offsets 2 and 3 are the low and high bytes of comparator A, and offsets 4 and 5 are the low and high bytes of comparator B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| busValid | input | 1 | Snooped bus cycle is valid |
| busRw | input | 1 | Snooped cycle direction, 1 = read |
| busAddr | input | ADDR_W | Snooped address |
| secure | input | 1 | Secure mode, blocks enabling |
| brkReq | output | 1 | Break request pulse |
| brkTag | output | 1 | Request type, 1 = tag, 0 = force |
| runDone | output | 1 | One-cycle run completion pulse |
| fifoRd | input | 1 | Pop the oldest trace entry |
| fifoDout | output | ADDR_W | Oldest trace entry |
| fifoLevel | output | LVL_W | Number of stored entries |
| fifoFull | output | 1 | FIFO holds FIFO_DEPTH entries |

## Verification
A software write to the control byte and a comparator hit can land on the same clock edge. The write is required to win and the hit to be dropped. The bench provokes this in two ways, each with a matching bus cycle driven in the same cycle as the write. The first write disarms the run. The second write re-arms it, which would also flush the FIFO. In both cases the bench judges the result at the ports: no completion pulse, no break, an unchanged FIFO level and the expected read-back of the control byte. It then checks that a later hit is still captured normally.

// File: rtl/bwt_pkg.sv
`timescale 1ns/1ps
package bwt_pkg;
  localparam int unsigned BIT_EN  = 7;
  localparam int unsigned BIT_ARM = 6;
  localparam int unsigned BIT_TAG = 5;
  localparam int unsigned BIT_BRK = 4;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_MODE = 3'd1;
  localparam logic [2:0] OFS_CMP0 = 3'd2;

  typedef struct packed {
    logic push;
    logic flush;
  } dpStrobe_t;
endpackage

// File: rtl/bwt_datapath.sv
`timescale 1ns/1ps
module bwt_datapath
  import bwt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [7:0]        regWdata,
  input  logic              busValid,
  input  logic              busRw,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        rwCfg,
  input  dpStrobe_t         strb,
  input  logic              fifoRd,
  output logic [ADDR_W-1:0] cmpVal [2],
  output logic              hit,
  output logic [ADDR_W-1:0] fifoDout,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic              fifoFull,
  output logic              fifoLast
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] PTR_TOP  = PTR_W'(DEPTH - 1);

  logic [1:0] hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < 2; c++) cmpVal[c] <= '0;
    end else if (regWe) begin
      for (int c = 0; c < 2; c++) begin
        if (regAddr == OFS_CMP0 + 3'(2 * c))
          cmpVal[c][7:0] <= regWdata;
        if (regAddr == OFS_CMP0 + 3'(2 * c + 1))
          cmpVal[c][ADDR_W-1:8] <= regWdata[ADDR_W-9:0];
      end
    end
  end

  // comparator c uses rwCfg[3-2c] as value, rwCfg[2-2c] as enable
  always_comb begin
    for (int c = 0; c < 2; c++) begin
      hitVec[c] = busValid && (busAddr == cmpVal[c]) &&
                  (!rwCfg[2 - 2 * c] || (busRw == rwCfg[3 - 2 * c]));
    end
  end
  assign hit = |hitVec;

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              doPush, doPop;

  assign fifoFull = (fifoLevel == FULL_LVL);
  assign fifoLast = (fifoLevel == LAST_LVL);
  assign doPush   = strb.push && !fifoFull;
  assign doPop    = fifoRd && (fifoLevel != '0);
  assign fifoDout = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !strb.flush) mem[wrPtr] <= busAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoLevel <= '0;
    end else if (strb.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoLevel <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_TOP) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_TOP) ? '0 : rdPtr + 1'b1;
      fifoLevel <= fifoLevel + LVL_W'(doPush) - LVL_W'(doPop);
    end
  end
endmodule

// File: rtl/bwt_control.sv
`timescale 1ns/1ps
module bwt_control
  import bwt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWdata,
  input  logic       secure,
  input  logic       hit,
  input  logic       fifoFull,
  input  logic       fifoLast,
  output logic [7:0] ctrlQ,
  output logic       beginMode,
  output dpStrobe_t  strb,
  output logic       brkReq,
  output logic       brkTag,
  output logic       runDone
);
  logic ctrlWr, modeWr, armed, trig, wrEn, done;

  assign ctrlWr = regWe && (regAddr == OFS_CTRL);
  assign modeWr = regWe && (regAddr == OFS_MODE);
  assign armed  = ctrlQ[BIT_EN] && ctrlQ[BIT_ARM];
  assign trig   = armed && hit && !ctrlWr;
  assign wrEn   = regWdata[BIT_EN] && !secure;

  assign strb.push  = trig && !fifoFull;
  assign strb.flush = ctrlWr && wrEn && regWdata[BIT_ARM];
  assign done       = beginMode ? (strb.push && fifoLast) : trig;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      beginMode <= 1'b0;
      brkReq    <= 1'b0;
      brkTag    <= 1'b0;
      runDone   <= 1'b0;
    end else begin
      if (ctrlWr)
        ctrlQ <= {wrEn, wrEn && regWdata[BIT_ARM], regWdata[5:0]};
      else if (secure) begin
        ctrlQ[BIT_EN]  <= 1'b0;
        ctrlQ[BIT_ARM] <= 1'b0;
      end else if (done)
        ctrlQ[BIT_ARM] <= 1'b0;
      if (modeWr) beginMode <= regWdata[0];
      brkReq  <= done && ctrlQ[BIT_BRK];
      brkTag  <= done && ctrlQ[BIT_BRK] && ctrlQ[BIT_TAG];
      runDone <= done;
    end
  end
endmodule

// File: rtl/bus_watch_trig.sv
`timescale 1ns/1ps
module bus_watch_trig
  import bwt_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int FIFO_DEPTH = 8,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              busValid,
  input  logic              busRw,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              secure,
  output logic              brkReq,
  output logic              brkTag,
  output logic              runDone,
  input  logic              fifoRd,
  output logic [ADDR_W-1:0] fifoDout,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic              fifoFull
);
  logic [7:0]        ctrlQ;
  logic              beginMode, hit, fifoLast;
  dpStrobe_t         strb;
  logic [ADDR_W-1:0] cmpVal [2];
  logic [15:0]       cmpA16, cmpB16;

  bwt_control u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .secure(secure), .hit(hit),
    .fifoFull(fifoFull), .fifoLast(fifoLast), .ctrlQ(ctrlQ),
    .beginMode(beginMode), .strb(strb), .brkReq(brkReq),
    .brkTag(brkTag), .runDone(runDone)
  );

  bwt_datapath #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .busValid(busValid), .busRw(busRw),
    .busAddr(busAddr), .rwCfg(ctrlQ[3:0]), .strb(strb), .fifoRd(fifoRd),
    .cmpVal(cmpVal), .hit(hit), .fifoDout(fifoDout),
    .fifoLevel(fifoLevel), .fifoFull(fifoFull), .fifoLast(fifoLast)
  );

  assign cmpA16 = 16'(cmpVal[0]);
  assign cmpB16 = 16'(cmpVal[1]);

  always_comb begin
    case (regAddr)
      3'd0:    regRdata = ctrlQ;
      3'd1:    regRdata = {7'd0, beginMode};
      3'd2:    regRdata = cmpA16[7:0];
      3'd3:    regRdata = cmpA16[15:8];
      3'd4:    regRdata = cmpB16[7:0];
      3'd5:    regRdata = cmpB16[15:8];
      default: regRdata = 8'd0;
    endcase
  end
endmodule

// File: rtl/bwt_checker.sv
`timescale 1ns/1ps
module bwt_checker #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             secure,
  input logic [7:0]       ctrlQ,
  input logic             brkReq,
  input logic             brkTag,
  input logic             runDone,
  input logic [LVL_W-1:0] fifoLevel
);
  a_r3_secure_blocks_enable: assert property (@(posedge clk) disable iff (!rstN)
    secure |=> !ctrlQ[7]);
  a_r6_done_clears_arm: assert property (@(posedge clk) disable iff (!rstN)
    runDone |-> !ctrlQ[6]);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    runDone |=> !runDone);
  a_r9_done_needs_armed: assert property (@(posedge clk) disable iff (!rstN)
    runDone |-> $past(ctrlQ[7] && ctrlQ[6]));
  a_r8_brk_with_done: assert property (@(posedge clk) disable iff (!rstN)
    brkReq |-> runDone);
  a_r8_brk_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    brkReq |-> ctrlQ[4]);
  a_r8_tag_only_with_req: assert property (@(posedge clk) disable iff (!rstN)
    brkTag |-> brkReq);
  a_r10_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(DEPTH));
endmodule

bind bus_watch_trig bwt_checker #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .secure(secure), .ctrlQ(ctrlQ),
  .brkReq(brkReq), .brkTag(brkTag), .runDone(runDone), .fifoLevel(fifoLevel)
);

// File: tb/test_bus_watch_trig.sv
`timescale 1ns/1ps
module test_bus_watch_trig;
  logic        clk = 0, rstN = 0;
  logic        regWe = 0, busValid = 0, busRw = 0, secure = 0, fifoRd = 0;
  logic [2:0]  regAddr = 0;
  logic [7:0]  regWdata = 0, regRdata;
  logic [15:0] busAddr = 0, fifoDout;
  logic [3:0]  fifoLevel;
  logic        brkReq, brkTag, runDone, fifoFull;

  int nChk = 0, nBad = 0, doneCnt = 0, brkCnt = 0, tagCnt = 0;
  bit finished = 0;
  logic [15:0] expQ [$];

  bus_watch_trig i_bus_watch_trig (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busValid(busValid),
    .busRw(busRw), .busAddr(busAddr), .secure(secure), .brkReq(brkReq),
    .brkTag(brkTag), .runDone(runDone), .fifoRd(fifoRd),
    .fifoDout(fifoDout), .fifoLevel(fifoLevel), .fifoFull(fifoFull)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (rstN) begin
    if (runDone) doneCnt++;
    if (brkReq)  brkCnt++;
    if (brkTag)  tagCnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic rdChk(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk); regAddr = a; #1;
    chk(req, regRdata, exp);
  endtask

  task automatic bus(input logic [15:0] a, input logic rw, input bit store);
    @(negedge clk); busValid = 1; busAddr = a; busRw = rw;
    if (store) expQ.push_back(a);
    @(negedge clk); busValid = 0; #1;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); #1;
      if (fifoLevel == 0) break;
      if (expQ.size() == 0) chk(req, fifoDout, 16'hxxxx);
      else chk(req, fifoDout, expQ.pop_front());
      fifoRd = 1;
      @(posedge clk); #1; fifoRd = 0;
    end
    chk(req, expQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rdChk("R1", 3'd0, 8'h00);
    chk("R1", fifoLevel, 0);
    chk("R1", {brkReq, brkTag, runDone}, 0);
    // R2 layout and readback
    wr(3'd0, 8'hBF); rdChk("R2", 3'd0, 8'hBF);
    wr(3'd0, 8'h00);
    // R3 secure
    secure = 1; wr(3'd0, 8'hC0); rdChk("R3", 3'd0, 8'h00); secure = 0;
    // R11 comparator registers
    wr(3'd2, 8'h34); wr(3'd3, 8'h12); wr(3'd4, 8'hEF); wr(3'd5, 8'hBE);
    rdChk("R11", 3'd3, 8'h12); rdChk("R11", 3'd4, 8'hEF);
    wr(3'd1, 8'h00); rdChk("R11", 3'd1, 8'h00);
    // R4 arm without enable
    wr(3'd0, 8'h40); rdChk("R4", 3'd0, 8'h00);
    // R5 R6 R8 end trace, A read-only, tag break
    wr(3'd0, 8'hFC);
    bus(16'h1234, 0, 0); bus(16'h1235, 1, 0);
    chk("R5", doneCnt, 0);
    bus(16'h1234, 1, 1);
    chk("R6", doneCnt, 1); chk("R8", brkCnt, 1); chk("R8", tagCnt, 1);
    rdChk("R6", 3'd0, 8'hBC);
    chk("R6", fifoLevel, 1);
    drain("R10");
    // R5 write-only, R8 break disabled
    wr(3'd0, 8'hC4);
    bus(16'h1234, 1, 0);
    chk("R5", doneCnt, 1);
    bus(16'h1234, 0, 1);
    chk("R8", doneCnt, 2); chk("R8", brkCnt, 1);
    rdChk("R8", 3'd0, 8'h84);
    drain("R8");
    // R8 force-type on B, rw ignored
    wr(3'd0, 8'hD0);
    bus(16'hBEEF, 0, 1);
    chk("R8", brkCnt, 2); chk("R8", tagCnt, 1); chk("R5", doneCnt, 3);
    drain("R5");
    // R7 begin trace
    wr(3'd1, 8'h01); wr(3'd0, 8'hD0);
    for (int i = 0; i < 8; i++) begin
      bus((i % 2 == 0) ? 16'h1234 : 16'hBEEF, 1'(i % 2), 1);
      bus(16'h0100, 1, 0);
      if (i == 6) begin
        chk("R7", fifoLevel, 7); chk("R7", fifoFull, 0); chk("R7", doneCnt, 3);
      end
    end
    chk("R7", fifoFull, 1); chk("R7", doneCnt, 4); chk("R7", brkCnt, 3);
    rdChk("R7", 3'd0, 8'h90);
    bus(16'h1234, 1, 0);
    chk("R7", fifoLevel, 8);
    drain("R7");
    // R9 stop by writing arm 0
    wr(3'd1, 8'h00); wr(3'd0, 8'hC0); wr(3'd0, 8'h80);
    bus(16'h1234, 1, 0);
    chk("R9", doneCnt, 4); chk("R9", fifoLevel, 0);
    // R9 hit in same cycle as disarming write
    wr(3'd0, 8'hC0);
    @(negedge clk); regWe = 1; regAddr = 0; regWdata = 8'h80;
    busValid = 1; busAddr = 16'h1234; busRw = 1;
    @(negedge clk); regWe = 0; busValid = 0; #1;
    chk("R9", doneCnt, 4); chk("R9", fifoLevel, 0);
    // R9 hit in same cycle as re-arming write
    wr(3'd0, 8'hC0);
    @(negedge clk); regWe = 1; regAddr = 0; regWdata = 8'hC0;
    busValid = 1; busAddr = 16'hBEEF; busRw = 0;
    @(negedge clk); regWe = 0; busValid = 0; #1;
    chk("R9", doneCnt, 4); chk("R9", fifoLevel, 0);
    rdChk("R9", 3'd0, 8'hC0);
    bus(16'hBEEF, 0, 1);
    chk("R9", doneCnt, 5);
    // R4 re-arm flushes a stored entry
    wr(3'd0, 8'hC0);
    chk("R4", fifoLevel, 0);
    expQ.delete();
    // R10 pop on empty
    @(negedge clk); fifoRd = 1; @(negedge clk); fifoRd = 0; #1;
    chk("R10", fifoLevel, 0);
    bus(16'h1234, 0, 1);
    drain("R10");
    finished = 1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule